// File: doc/BRIEF.md
# Interrupt context stack sequencer

This block moves processor context between registers and a byte-wide memory stack. It covers four operations: interrupt entry, interrupt return, subroutine call and subroutine return. It keeps a 16-bit stack pointer S. Every stack access goes to a 24-bit address: a bank byte in the upper eight bits and S below it. A bank-select input, sampled when an operation starts, picks the bank: 0x00 or 0xFF.

Interrupt entry pushes a five-byte frame:

- the program bank byte,
- the program counter, high byte then low byte,
- the status word, high byte then low byte.

Interrupt return reads the frame back in the opposite order. A subroutine call pushes the same frame without the status bytes. A mode input decides whether a call also stores the bank byte, and the matching return restores the bank byte only in that mode. Software loads S through a write strobe, because S holds no defined value after reset.

Operations are started by one-cycle pulses. The block makes one memory access per clock. Busy stays high until a one-cycle done strobe, and the restored bank, program counter and status word are valid in that done cycle.

Top module: `ctx_stack_seq`

## Requirements
- R1: During and right after reset, busy, done, mem_we and mem_re are all low.
- R2: With the block idle, a pulse on sp_wr loads sp_wdata into S, and sp_out shows the new value on the next cycle. A pulse on sp_wr while busy has no effect on S.
- R3: Every access address has bits 23:16 equal to 0x00 when stack_bank_hi was 0 at the start pulse, or 0xFF when it was 1. This bank byte stays fixed for the whole operation, even if stack_bank_hi changes.
- R4: Interrupt entry writes five bytes, in this order, to bank:S, S-1, S-2, S-3 and S-4: the bank byte, PC[15:8], PC[7:0], PSW[15:8], PSW[7:0]. Afterwards S equals its starting value minus 5.
- R5: Interrupt return reads S+1 through S+5. These give, in order, PSW[7:0], PSW[15:8], PC[7:0], PC[15:8] and the bank byte. Afterwards S equals its starting value plus 5.
- R6: A subroutine call never writes the status word. With call_far=1 it writes the bank byte, PC[15:8] and PC[7:0] at S, S-1 and S-2, and S drops by 3. With call_far=0 it writes PC[15:8] and PC[7:0] at S and S-1, and S drops by 2.
- R7: A subroutine return reads PC[7:0] and then PC[15:8] from S+1 and S+2. With call_far=1 it also reads the bank byte from S+3. Any output it does not restore (the status word, and the bank byte when call_far=0) shows the cur_* value present at the start pulse.
- R8: S wraps modulo 2^16, and the bank byte never changes because of pointer arithmetic. For example, a write at 0x0000 is followed by a write at 0xFFFF in the same bank.
- R9: Accesses run one per cycle, starting in the cycle after the start pulse is accepted, with at most one of mem_we and mem_re high. One idle cycle follows the last access. Then done is high for exactly one cycle. Busy is high from the first access through the done cycle.
- R10: Start pulses that arrive while busy are ignored. A start pulse in the same cycle as sp_wr is ignored. When several start pulses arrive together, the priority is: interrupt entry, then interrupt return, then call, then return.
- R11: rst_bank, rst_pc and rst_psw hold the restored values in the cycle that done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stack_bank_hi | input | 1 | Stack bank select: 0 selects bank 0x00, 1 selects bank 0xFF |
| sp_wr | input | 1 | Software write strobe for S |
| sp_wdata | input | 16 | New value for S |
| irq_enter | input | 1 | Start pulse for interrupt entry |
| irq_leave | input | 1 | Start pulse for interrupt return |
| call_enter | input | 1 | Start pulse for subroutine call |
| call_leave | input | 1 | Start pulse for subroutine return |
| call_far | input | 1 | Call and return also move the bank byte |
| cur_bank | input | 8 | Current program bank |
| cur_pc | input | 16 | Current program counter |
| cur_psw | input | 16 | Current status word |
| mem_addr | output | 24 | Stack memory address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable; data is expected on mem_rdata one cycle later |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| sp_out | output | 16 | Current stack pointer |
| rst_bank | output | 8 | Restored program bank |
| rst_pc | output | 16 | Restored program counter |
| rst_psw | output | 16 | Restored status word |

## Verification
The assertions watch several properties on every cycle:

- accesses happen only while busy, and never a read and a write together;
- the address bank byte is 0x00 or 0xFF and stays fixed for the whole operation;
- S moves by exactly one after each write or read, and takes the loaded value after an accepted software write;
- the operation stays locked while it runs, and done lasts a single cycle.

Other behaviour depends on the contents of a whole operation, so only the bench scenarios can show it. This covers the byte order and frame length for each mode, the values restored from memory, the echo of values that were not restored, wrap at 0x0000/0xFFFF, start priority, and the dropping of pulses while busy or alongside a software write.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_IRQ  = 3'd1,
    OP_RTI  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    K_BANK = 3'd0,
    K_PCH  = 3'd1,
    K_PCL  = 3'd2,
    K_PSH  = 3'd3,
    K_PSL  = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FIN   = 2'd3
  } st_e;

  localparam int unsigned FRAME_MAX = 5;
  localparam int unsigned IDX_W     = $clog2(FRAME_MAX);

  function automatic logic op_is_push(op_e op);
    return (op == OP_IRQ) || (op == OP_CALL);
  endfunction

  // number of bytes moved by an operation
  function automatic logic [IDX_W-1:0] frame_len(op_e op, logic far);
    case (op)
      OP_IRQ, OP_RTI:  frame_len = IDX_W'(FRAME_MAX);
      OP_CALL, OP_RET: frame_len = far ? IDX_W'(3) : IDX_W'(2);
      default:         frame_len = IDX_W'(1);
    endcase
  endfunction

  // which byte of the frame is moved in slot idx
  function automatic kind_e slot_kind(op_e op, logic far, logic [IDX_W-1:0] idx);
    logic [IDX_W-1:0] k;
    if (op_is_push(op)) begin
      k = idx + ((op == OP_CALL && !far) ? IDX_W'(1) : IDX_W'(0));
      case (k)
        IDX_W'(0): slot_kind = K_BANK;
        IDX_W'(1): slot_kind = K_PCH;
        IDX_W'(2): slot_kind = K_PCL;
        IDX_W'(3): slot_kind = K_PSH;
        default:   slot_kind = K_PSL;
      endcase
    end else begin
      k = idx + ((op == OP_RTI) ? IDX_W'(0) : IDX_W'(2));
      case (k)
        IDX_W'(0): slot_kind = K_PSL;
        IDX_W'(1): slot_kind = K_PSH;
        IDX_W'(2): slot_kind = K_PCL;
        IDX_W'(3): slot_kind = K_PCH;
        default:   slot_kind = K_BANK;
      endcase
    end
  endfunction

endpackage

// File: rtl/ctx_sp_reg.sv
module ctx_sp_reg #(
  parameter int unsigned SP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [SP_W-1:0] load_val,
  input  logic            dec,
  input  logic            inc,
  output logic [SP_W-1:0] sp_q,
  output logic [SP_W-1:0] sp_up
);

  function automatic logic [SP_W-1:0] sp_minus1(logic [SP_W-1:0] s);
    return s - SP_W'(1);
  endfunction

  function automatic logic [SP_W-1:0] sp_plus1(logic [SP_W-1:0] s);
    return s + SP_W'(1);
  endfunction

  // S has no reset value: software must load it before use
  always_ff @(posedge clk) begin
    if (load)     sp_q <= load_val;
    else if (dec) sp_q <= sp_minus1(sp_q);
    else if (inc) sp_q <= sp_plus1(sp_q);
  end

  assign sp_up = sp_plus1(sp_q);

  // R2
  sp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sp_q == $past(load_val)));

  // R8
  sp_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |=> (sp_q == $past(sp_q) - SP_W'(1)));

  // R8
  sp_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && !dec) |=> (sp_q == $past(sp_q) + SP_W'(1)));

endmodule

// File: rtl/ctx_seq_ctrl.sv
module ctx_seq_ctrl
  import ctx_stack_pkg::*;
#(
  parameter int unsigned BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_irq,
  input  logic              go_rti,
  input  logic              go_call,
  input  logic              go_ret,
  input  logic              sp_wr,
  input  logic              far_in,
  input  logic              bank_hi_in,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output logic              acc_en,
  output logic              push_en,
  output kind_e             kind,
  output logic [BANK_W-1:0] bank_byte
);

  st_e              st_q;
  op_e              op_q;
  op_e              req_op;
  logic [IDX_W-1:0] idx_q;
  logic             far_q;
  logic             sel_q;
  logic             last;

  // fixed start priority
  always_comb begin
    if (go_irq)       req_op = OP_IRQ;
    else if (go_rti)  req_op = OP_RTI;
    else if (go_call) req_op = OP_CALL;
    else if (go_ret)  req_op = OP_RET;
    else              req_op = OP_NONE;
  end

  assign accept = (st_q == ST_IDLE) && !sp_wr && (req_op != OP_NONE);
  assign last   = (idx_q == frame_len(op_q, far_q) - IDX_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      op_q  <= OP_NONE;
      idx_q <= '0;
      far_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q  <= ST_RUN;
          op_q  <= req_op;
          idx_q <= '0;
          far_q <= far_in;
          sel_q <= bank_hi_in;
        end
        ST_RUN: begin
          if (last) st_q  <= ST_DRAIN;
          else      idx_q <= idx_q + IDX_W'(1);
        end
        ST_DRAIN: st_q <= ST_FIN;
        default: begin
          st_q <= ST_IDLE;
          op_q <= OP_NONE;
        end
      endcase
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_FIN);
  assign acc_en    = (st_q == ST_RUN);
  assign push_en   = op_is_push(op_q);
  assign kind      = slot_kind(op_q, far_q, idx_q);
  assign bank_byte = sel_q ? {BANK_W{1'b1}} : {BANK_W{1'b0}};

  // R10
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RUN) || (st_q == ST_DRAIN)) |=> $stable(op_q));

  // R3
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sel_q));

  // R9
  run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RUN) && !last) |=> ((st_q == ST_RUN) && (idx_q == $past(idx_q) + IDX_W'(1))));

endmodule

// File: rtl/ctx_frame_regs.sv
module ctx_frame_regs
  import ctx_stack_pkg::*;
#(
  parameter int unsigned BANK_W = 8,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                latch,
  input  logic [BANK_W-1:0]   cur_bank,
  input  logic [2*BYTE_W-1:0] cur_pc,
  input  logic [2*BYTE_W-1:0] cur_psw,
  input  kind_e               wr_kind,
  input  logic                rd_issue,
  input  kind_e               rd_kind,
  input  logic [BYTE_W-1:0]   rdata,
  output logic [BANK_W-1:0]   bank_q,
  output logic [2*BYTE_W-1:0] pc_q,
  output logic [2*BYTE_W-1:0] psw_q,
  output logic [BYTE_W-1:0]   wbyte
);

  localparam int unsigned WORD_W = 2 * BYTE_W;

  logic  rd_vld_q;
  kind_e rd_kind_q;

  // one-cycle record of the read in flight
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld_q  <= 1'b0;
      rd_kind_q <= K_BANK;
    end else begin
      rd_vld_q  <= rd_issue;
      rd_kind_q <= rd_kind;
    end
  end

  // context registers: source for pushes, destination for pops
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
      pc_q   <= '0;
      psw_q  <= '0;
    end else if (latch) begin
      bank_q <= cur_bank;
      pc_q   <= cur_pc;
      psw_q  <= cur_psw;
    end else if (rd_vld_q) begin
      case (rd_kind_q)
        K_BANK:  bank_q                  <= BANK_W'(rdata);
        K_PCH:   pc_q[WORD_W-1:BYTE_W]   <= rdata;
        K_PCL:   pc_q[BYTE_W-1:0]        <= rdata;
        K_PSH:   psw_q[WORD_W-1:BYTE_W]  <= rdata;
        default: psw_q[BYTE_W-1:0]       <= rdata;
      endcase
    end
  end

  always_comb begin
    case (wr_kind)
      K_BANK:  wbyte = BYTE_W'(bank_q);
      K_PCH:   wbyte = pc_q[WORD_W-1:BYTE_W];
      K_PCL:   wbyte = pc_q[BYTE_W-1:0];
      K_PSH:   wbyte = psw_q[WORD_W-1:BYTE_W];
      default: wbyte = psw_q[BYTE_W-1:0];
    endcase
  end

  // R11
  latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> ((pc_q == $past(cur_pc)) && (psw_q == $past(cur_psw)) && (bank_q == $past(cur_bank))));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch && !rd_vld_q) |=> ($stable(pc_q) && $stable(psw_q) && $stable(bank_q)));

endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq
  import ctx_stack_pkg::*;
#(
  parameter int unsigned SP_W   = 16,
  parameter int unsigned BANK_W = 8,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       stack_bank_hi,
  input  logic                       sp_wr,
  input  logic [SP_W-1:0]            sp_wdata,
  input  logic                       irq_enter,
  input  logic                       irq_leave,
  input  logic                       call_enter,
  input  logic                       call_leave,
  input  logic                       call_far,
  input  logic [BANK_W-1:0]          cur_bank,
  input  logic [2*BYTE_W-1:0]        cur_pc,
  input  logic [2*BYTE_W-1:0]        cur_psw,
  output logic [BANK_W+SP_W-1:0]     mem_addr,
  output logic                       mem_we,
  output logic                       mem_re,
  output logic [BYTE_W-1:0]          mem_wdata,
  input  logic [BYTE_W-1:0]          mem_rdata,
  output logic                       busy,
  output logic                       done,
  output logic [SP_W-1:0]            sp_out,
  output logic [BANK_W-1:0]          rst_bank,
  output logic [2*BYTE_W-1:0]        rst_pc,
  output logic [2*BYTE_W-1:0]        rst_psw
);

  localparam int unsigned ADDR_W = BANK_W + SP_W;

  logic              accept;
  logic              acc_en;
  logic              push_en;
  kind_e             kind;
  logic [BANK_W-1:0] bank_byte;
  logic [SP_W-1:0]   sp_q;
  logic [SP_W-1:0]   sp_up;
  logic              sp_load_en;
  logic              sp_dec_en;
  logic              sp_inc_en;

  assign sp_load_en = sp_wr && !busy;
  assign sp_dec_en  = acc_en && push_en;
  assign sp_inc_en  = acc_en && !push_en;

  ctx_seq_ctrl #(.BANK_W(BANK_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_irq     (irq_enter),
    .go_rti     (irq_leave),
    .go_call    (call_enter),
    .go_ret     (call_leave),
    .sp_wr      (sp_wr),
    .far_in     (call_far),
    .bank_hi_in (stack_bank_hi),
    .accept     (accept),
    .busy       (busy),
    .done       (done),
    .acc_en     (acc_en),
    .push_en    (push_en),
    .kind       (kind),
    .bank_byte  (bank_byte)
  );

  ctx_sp_reg #(.SP_W(SP_W)) u_sp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sp_load_en),
    .load_val (sp_wdata),
    .dec      (sp_dec_en),
    .inc      (sp_inc_en),
    .sp_q     (sp_q),
    .sp_up    (sp_up)
  );

  ctx_frame_regs #(.BANK_W(BANK_W), .BYTE_W(BYTE_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch    (accept),
    .cur_bank (cur_bank),
    .cur_pc   (cur_pc),
    .cur_psw  (cur_psw),
    .wr_kind  (kind),
    .rd_issue (mem_re),
    .rd_kind  (kind),
    .rdata    (mem_rdata),
    .bank_q   (rst_bank),
    .pc_q     (rst_pc),
    .psw_q    (rst_psw),
    .wbyte    (mem_wdata)
  );

  // push writes at S then steps down; pop steps up then reads
  assign mem_addr = {bank_byte, (push_en ? sp_q : sp_up)};
  assign mem_we   = sp_dec_en;
  assign mem_re   = sp_inc_en;
  assign sp_out   = sp_q;

  // R9
  access_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (busy && !(mem_we && mem_re)));

  // R3
  bank_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> ((mem_addr[ADDR_W-1:SP_W] == {BANK_W{1'b0}}) ||
                            (mem_addr[ADDR_W-1:SP_W] == {BANK_W{1'b1}})));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R4
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp_out == $past(mem_addr[SP_W-1:0]) - SP_W'(1)));

  // R5
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (sp_out == $past(mem_addr[SP_W-1:0])));

endmodule

// File: tb/ctx_stack_seq_tb.sv
module ctx_stack_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        stack_bank_hi, sp_wr, irq_enter, irq_leave, call_enter, call_leave, call_far;
  logic [15:0] sp_wdata, cur_pc, cur_psw, sp_out, rst_pc, rst_psw;
  logic [7:0]  cur_bank, mem_wdata, rst_bank;
  logic [7:0]  mem_rdata = 8'h00;
  logic [23:0] mem_addr;
  logic        mem_we, mem_re, busy, done;

  always #5 clk = ~clk;

  ctx_stack_seq u_dut (
    .clk(clk), .rst_n(rst_n), .stack_bank_hi(stack_bank_hi), .sp_wr(sp_wr),
    .sp_wdata(sp_wdata), .irq_enter(irq_enter), .irq_leave(irq_leave),
    .call_enter(call_enter), .call_leave(call_leave), .call_far(call_far),
    .cur_bank(cur_bank), .cur_pc(cur_pc), .cur_psw(cur_psw),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .sp_out(sp_out),
    .rst_bank(rst_bank), .rst_pc(rst_pc), .rst_psw(rst_psw)
  );

  logic [7:0] mem [int];

  function automatic logic [7:0] rd_mem(int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    if (mem_re) mem_rdata <= rd_mem(int'(mem_addr));
  end

  int n_chk = 0;
  int n_fail = 0;
  int sp_m = 0;
  int          ea[$];
  logic [7:0]  ed[$];
  bit          ew[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_sp(input logic [15:0] v);
    @(negedge clk);
    sp_wr = 1'b1; sp_wdata = v;
    @(negedge clk);
    sp_wr = 1'b0;
    chk(sp_out == v, "R2 load", 32'(sp_out), 32'(v));
    sp_m = int'(v);
  endtask

  // op: 1 irq entry, 2 irq return, 3 call, 4 return
  task automatic run_op(input int op, input bit far, input bit bsel, input logic [7:0] b,
                        input logic [15:0] pc, input logic [15:0] psw, input bit glitch, input bit dual);
    int base;
    int cnt;
    int a;
    int sp0;
    string rq;
    logic [7:0] bytes[$];
    logic [7:0] xb;
    logic [15:0] xpc, xpsw;
    base = bsel ? 32'h00FF0000 : 32'h0;
    rq = (op == 1) ? "R4" : (op == 2) ? "R5" : (op == 3) ? "R6" : "R7";
    ea.delete(); ed.delete(); ew.delete();
    xb = b; xpc = pc; xpsw = psw;
    sp0 = sp_m;
    if (op == 1 || op == 3) begin
      if (op == 1 || far) bytes.push_back(b);
      bytes.push_back(pc[15:8]);
      bytes.push_back(pc[7:0]);
      if (op == 1) begin
        bytes.push_back(psw[15:8]);
        bytes.push_back(psw[7:0]);
      end
      foreach (bytes[i]) begin
        ea.push_back(base | sp_m); ed.push_back(bytes[i]); ew.push_back(1'b1);
        sp_m = (sp_m - 1) & 32'hFFFF;
      end
    end else begin
      cnt = (op == 2) ? 5 : (far ? 3 : 2);
      for (int i = 0; i < cnt; i++) begin
        int j;
        sp_m = (sp_m + 1) & 32'hFFFF;
        a = base | sp_m;
        ea.push_back(a); ed.push_back(rd_mem(a)); ew.push_back(1'b0);
        j = (op == 2) ? i : i + 2;
        case (j)
          0: xpsw[7:0]  = rd_mem(a);
          1: xpsw[15:8] = rd_mem(a);
          2: xpc[7:0]   = rd_mem(a);
          3: xpc[15:8]  = rd_mem(a);
          default: xb   = rd_mem(a);
        endcase
      end
    end
    @(negedge clk);
    cur_bank = b; cur_pc = pc; cur_psw = psw; stack_bank_hi = bsel; call_far = far;
    irq_enter = (op == 1); irq_leave = (op == 2); call_enter = (op == 3) || dual; call_leave = (op == 4);
    @(negedge clk);
    irq_enter = 0; irq_leave = 0; call_enter = 0; call_leave = 0;
    for (int c = 0; c < ea.size(); c++) begin
      chk(busy && !done, "R9 busy", {30'd0, busy, done}, 32'h2);
      chk(mem_we == ew[c] && mem_re == !ew[c], {rq, " access type"}, {30'd0, mem_we, mem_re}, {30'd0, ew[c], !ew[c]});
      chk(int'(mem_addr) == ea[c], {rq, " R3 address"}, 32'(mem_addr), 32'(ea[c]));
      if (ew[c]) chk(mem_wdata == ed[c], {rq, " write byte"}, 32'(mem_wdata), 32'(ed[c]));
      if (glitch && c == 1) begin
        irq_enter = 1; call_enter = 1; sp_wr = 1; sp_wdata = 16'hDEAD;
        stack_bank_hi = !bsel; call_far = !far;
      end
      @(negedge clk);
      if (glitch && c == 1) begin
        irq_enter = 0; call_enter = 0; sp_wr = 0; stack_bank_hi = bsel; call_far = far;
      end
    end
    chk(busy && !done && !mem_we && !mem_re, "R9 drain", {28'd0, busy, done, mem_we, mem_re}, 32'h8);
    @(negedge clk);
    chk(done && busy, "R9 done", {30'd0, busy, done}, 32'h3);
    chk(int'(sp_out) == sp_m, {rq, " final S"}, 32'(sp_out), 32'(sp_m));
    if (glitch) chk(int'(sp_out) == sp_m, "R10 ignored load", 32'(sp_out), 32'(sp_m));
    if (op == 2 || op == 4) begin
      chk(rst_bank == xb, {rq, " R11 bank"}, 32'(rst_bank), 32'(xb));
      chk(rst_pc == xpc, {rq, " R11 pc"}, 32'(rst_pc), 32'(xpc));
      chk(rst_psw == xpsw, {rq, " R11 psw"}, 32'(rst_psw), 32'(xpsw));
    end
    @(negedge clk);
    chk(!busy && !done && !mem_we && !mem_re, "R9 idle after done", {28'd0, busy, done, mem_we, mem_re}, 32'h0);
    if (sp0 < 0) $display("unreachable");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; stack_bank_hi = 0; sp_wr = 0; sp_wdata = 0;
    irq_enter = 0; irq_leave = 0; call_enter = 0; call_leave = 0; call_far = 0;
    cur_bank = 0; cur_pc = 0; cur_psw = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_we && !mem_re, "R1 in reset", {28'd0, busy, done, mem_we, mem_re}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !mem_we && !mem_re, "R1 after reset", {28'd0, busy, done, mem_we, mem_re}, 0);

    // R4 / R5: single interrupt entry and return, bank 0x00
    load_sp(16'h1000);
    run_op(1, 0, 0, 8'h12, 16'h3456, 16'hA5C3, 0, 0);
    run_op(2, 0, 0, 8'h00, 16'h0000, 16'h0000, 0, 0);
    chk(sp_out == 16'h1000, "R5 S restored", 32'(sp_out), 32'h1000);

    // nested interrupts
    run_op(1, 0, 0, 8'h21, 16'h1111, 16'h2222, 0, 0);
    run_op(1, 0, 0, 8'h31, 16'h3333, 16'h4444, 0, 0);
    run_op(2, 0, 0, 8'h00, 16'h0000, 16'h0000, 0, 0);
    run_op(2, 0, 0, 8'h00, 16'h0000, 16'h0000, 0, 0);

    // R8: wrap in bank 0xFF with a far call and return
    load_sp(16'h0001);
    run_op(3, 1, 1, 8'h7E, 16'hBEEF, 16'h9999, 0, 0);
    chk(sp_out == 16'hFFFE, "R8 wrap", 32'(sp_out), 32'hFFFE);
    run_op(4, 1, 1, 8'h55, 16'h0000, 16'h1234, 0, 0);

    // R6 / R7: near call and return, unrestored outputs echo
    load_sp(16'h8000);
    run_op(3, 0, 0, 8'h44, 16'hCAFE, 16'hF00D, 0, 0);
    run_op(4, 0, 0, 8'h66, 16'h0000, 16'h0BAD, 0, 0);

    // R10: pulses while busy, bank select and mode changes mid-operation
    run_op(1, 0, 1, 8'h9A, 16'h7654, 16'h3210, 1, 0);
    run_op(2, 0, 1, 8'h00, 16'h0000, 16'h0000, 1, 0);

    // R10: entry and call together, entry wins
    run_op(1, 0, 0, 8'hC1, 16'h0F0F, 16'hF0F0, 0, 1);
    run_op(2, 0, 0, 8'h00, 16'h0000, 16'h0000, 0, 0);

    // R10: start together with a software write is dropped
    @(negedge clk);
    sp_wr = 1; sp_wdata = 16'h2000; call_enter = 1;
    @(negedge clk);
    sp_wr = 0; call_enter = 0;
    chk(!busy && !mem_we && sp_out == 16'h2000, "R10 start with load", {busy, mem_we, sp_out}, 32'h2000);
    @(negedge clk);
    chk(!busy && !mem_we && !mem_re, "R10 stays idle", {29'd0, busy, mem_we, mem_re}, 0);

    // R2: software write while busy is dropped
    sp_m = 16'h2000;
    run_op(3, 1, 0, 8'h0A, 16'h0B0C, 16'h0000, 1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule